// File: doc/BRIEF.md
# Prioritized Next-Fetch-Address Selector

This block owns the instruction-fetch address register of a superscalar front end. Each cycle it weighs four redirect sources against the plain sequential path. The sources are an exception vector, a branch-unit correction, a decode-stage correction of an earlier target-cache guess, and a target-cache hit. It loads the winner as the fetch address for the next cycle. The source latest in the pipeline always wins.

Alongside the address it reports how many instructions the current fetch group holds. A group starts on a double-word boundary and holds at most four 32-bit instructions. It never runs past the end of a 32-byte cache block, so a group that starts two words before the block end holds only two. When the pipeline is redirected by a late stage, the block raises a one-cycle flush strobe so that the instruction buffers drop their wrong-path contents. The buffer-full indication is accepted but does not hold the fetch address. Fetching runs ahead because buffer space may free up before the cache returns data.

Top module: `fetch_redirect_sel`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `fetchAddr` equals the parameter `RESET_VEC` (default 0x0000_0100), `groupCount` is 4 and `flush` is 0.
- R2: When `excValid` is high at a clock edge, the next `fetchAddr` is `excAddr` aligned down to 8 bytes, whatever the other request inputs are, and `flush` is 1 in that next cycle.
- R3: When `bruValid` is high and `excValid` is low, the next `fetchAddr` is the aligned `bruAddr` and `flush` is 1 in that next cycle.
- R4: When `decFixValid` is high and `excValid` and `bruValid` are low, the next `fetchAddr` is the aligned `decFixAddr` and `flush` is 1.
- R5: When `btacHit` is the only active request, the next `fetchAddr` is the aligned `btacTarget` and `flush` is 0.
- R6: With no active request, the next `fetchAddr` is `fetchAddr + 4*groupCount`.
- R7: `groupCount` is min(4, 8 - fetchAddr[4:2]). This gives 4 for word index 0, 2 or 4 and 2 for word index 6. The group never spans two 32-byte blocks.
- R8: `fetchAddr[2:0]` is always zero. Every redirect target is aligned down to a multiple of 8 bytes.
- R9: After a two-instruction group at the end of a block, the sequential fetch address is the start of the next block and `groupCount` is 4.
- R10: `flush` is high for exactly those cycles that follow an edge at which an exception, branch-unit or decode-correction request was taken. It is 0 after sequential steps and target-cache redirects.
- R11: `bufFull` has no effect. With no request active, the fetch address advances sequentially as in R6 while `bufFull` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| excValid | input | 1 | Exception vector request |
| excAddr | input | 32 | Exception handler address |
| bruValid | input | 1 | Branch-unit redirect request |
| bruAddr | input | 32 | Branch-unit corrected address |
| decFixValid | input | 1 | Decode-stage correction of a target-cache prediction |
| decFixAddr | input | 32 | Decode-stage corrected address |
| btacHit | input | 1 | Target cache hit on the current fetch address |
| btacTarget | input | 32 | Predicted target from the target cache |
| bufFull | input | 1 | Instruction buffer full (does not stall fetch) |
| fetchAddr | output | 32 | Current fetch-group start address |
| groupCount | output | 3 | Instructions in the current fetch group (2 or 4) |
| flush | output | 1 | One-cycle strobe: discard instruction buffers |

## Verification
The selector is driven with every request alone and with each request together with all lower-priority ones. Because every source carries a different address, the loaded address shows which source won, and `flush` separates the flushing sources from the target-cache guess. Sequential runs start at block offsets 0, 8 and 24 bytes, so full and trimmed groups and the step into the next block can each be told apart. A misaligned target shows the rounding. A run with `bufFull` held high shows that the sequential advance does not depend on it.

// File: rtl/fetch_sel_pkg.sv
package fetch_sel_pkg;

  typedef enum logic [2:0] {
    SRC_SEQ  = 3'd0,
    SRC_BTAC = 3'd1,
    SRC_DEC  = 3'd2,
    SRC_BRU  = 3'd3,
    SRC_EXC  = 3'd4
  } srcSel_e;

  typedef struct packed {
    srcSel_e sel;
    logic    flush;
  } fetchStrobe_t;

endpackage

// File: rtl/fetch_sel_ctrl.sv
module fetch_sel_ctrl
  import fetch_sel_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         excValid,
  input  logic         bruValid,
  input  logic         decFixValid,
  input  logic         btacHit,
  output fetchStrobe_t strobe
);

  // Latest pipeline stage wins: exception, branch unit, decode fix, target cache.
  always_comb begin
    strobe.sel   = SRC_SEQ;
    strobe.flush = 1'b0;
    if (excValid) begin
      strobe.sel   = SRC_EXC;
      strobe.flush = 1'b1;
    end else if (bruValid) begin
      strobe.sel   = SRC_BRU;
      strobe.flush = 1'b1;
    end else if (decFixValid) begin
      strobe.sel   = SRC_DEC;
      strobe.flush = 1'b1;
    end else if (btacHit) begin
      strobe.sel   = SRC_BTAC;
    end
  end

  // R5: a target-cache guess alone never requests a flush
  assert_btac_no_flush_R5: assert property (@(posedge clk) disable iff (!rstN)
    (btacHit && !excValid && !bruValid && !decFixValid) |-> (strobe.sel == SRC_BTAC && !strobe.flush));

  // R4: decode fix outranks target cache but yields to later stages
  assert_dec_rank_R4: assert property (@(posedge clk) disable iff (!rstN)
    (decFixValid && !excValid && !bruValid) |-> (strobe.sel == SRC_DEC));

endmodule

// File: rtl/fetch_sel_dpath.sv
module fetch_sel_dpath
  import fetch_sel_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          BLOCK_WORDS = 8,
  parameter int          GROUP_MAX   = 4,
  parameter logic [31:0] RESET_VEC   = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  fetchStrobe_t      strobe,
  input  logic [ADDR_W-1:0] excAddr,
  input  logic [ADDR_W-1:0] bruAddr,
  input  logic [ADDR_W-1:0] decFixAddr,
  input  logic [ADDR_W-1:0] btacTarget,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [$clog2(GROUP_MAX+1)-1:0] groupCount,
  output logic              flush
);

  localparam int WORD_BYTES = 4;
  localparam int DW_BYTES   = 2 * WORD_BYTES;
  localparam int IDX_W      = $clog2(BLOCK_WORDS);
  localparam int CNT_W      = $clog2(GROUP_MAX + 1);
  localparam logic [ADDR_W-1:0] DW_MASK = ~ADDR_W'(DW_BYTES - 1);

  logic [ADDR_W-1:0] pcQ, pcD, seqNext;
  logic              flushQ;
  logic [IDX_W:0]    wordsLeft;
  logic [CNT_W-1:0]  grpCnt;

  // Words remaining in the cache block from the current group start.
  assign wordsLeft = (IDX_W+1)'(BLOCK_WORDS) - {1'b0, pcQ[IDX_W+1:2]};
  assign grpCnt    = (wordsLeft < (IDX_W+1)'(GROUP_MAX)) ? CNT_W'(wordsLeft) : CNT_W'(GROUP_MAX);
  assign seqNext   = pcQ + (ADDR_W'(grpCnt) << 2);

  always_comb begin
    unique case (strobe.sel)
      SRC_EXC:  pcD = excAddr    & DW_MASK;
      SRC_BRU:  pcD = bruAddr    & DW_MASK;
      SRC_DEC:  pcD = decFixAddr & DW_MASK;
      SRC_BTAC: pcD = btacTarget & DW_MASK;
      default:  pcD = seqNext;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ    <= RESET_VEC[ADDR_W-1:0] & DW_MASK;
      flushQ <= 1'b0;
    end else begin
      pcQ    <= pcD;
      flushQ <= strobe.flush;
    end
  end

  assign fetchAddr  = pcQ;
  assign groupCount = grpCnt;
  assign flush      = flushQ;

  // R8: group start stays double-word aligned
  assert_aligned_R8: assert property (@(posedge clk) disable iff (!rstN)
    fetchAddr[2:0] == 3'b000);

  // R7: a group is non-empty and ends inside its cache block
  assert_in_block_R7: assert property (@(posedge clk) disable iff (!rstN)
    (groupCount != '0) &&
    ((32'(fetchAddr[IDX_W+1:2]) + 32'(groupCount)) <= 32'(BLOCK_WORDS)));

endmodule

// File: rtl/fetch_redirect_sel.sv
module fetch_redirect_sel
  import fetch_sel_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          BLOCK_WORDS = 8,
  parameter int          GROUP_MAX   = 4,
  parameter logic [31:0] RESET_VEC   = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excValid,
  input  logic [ADDR_W-1:0] excAddr,
  input  logic              bruValid,
  input  logic [ADDR_W-1:0] bruAddr,
  input  logic              decFixValid,
  input  logic [ADDR_W-1:0] decFixAddr,
  input  logic              btacHit,
  input  logic [ADDR_W-1:0] btacTarget,
  input  logic              bufFull,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [$clog2(GROUP_MAX+1)-1:0] groupCount,
  output logic              flush
);

  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(7);

  fetchStrobe_t strobe;
  logic         anyReq;

  assign anyReq = excValid | bruValid | decFixValid | btacHit;

  fetch_sel_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .excValid    (excValid),
    .bruValid    (bruValid),
    .decFixValid (decFixValid),
    .btacHit     (btacHit),
    .strobe      (strobe)
  );

  fetch_sel_dpath #(
    .ADDR_W      (ADDR_W),
    .BLOCK_WORDS (BLOCK_WORDS),
    .GROUP_MAX   (GROUP_MAX),
    .RESET_VEC   (RESET_VEC)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .excAddr    (excAddr),
    .bruAddr    (bruAddr),
    .decFixAddr (decFixAddr),
    .btacTarget (btacTarget),
    .fetchAddr  (fetchAddr),
    .groupCount (groupCount),
    .flush      (flush)
  );

  // R2: exception request always wins and flushes
  assert_exc_wins_R2: assert property (@(posedge clk) disable iff (!rstN)
    excValid |=> (flush && fetchAddr == ($past(excAddr) & ALIGN_MASK)));

  // R3: branch-unit redirect is taken below an exception and flushes
  assert_bru_flush_R3: assert property (@(posedge clk) disable iff (!rstN)
    (bruValid && !excValid) |=> (flush && fetchAddr == ($past(bruAddr) & ALIGN_MASK)));

  // R10: flush only follows a flushing request
  assert_flush_source_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!excValid && !bruValid && !decFixValid) |=> !flush);

  // R11: a full buffer does not hold the sequential advance
  assert_full_ignored_R11: assert property (@(posedge clk) disable iff (!rstN)
    (bufFull && !anyReq) |=>
      (fetchAddr == $past(fetchAddr) + (ADDR_W'($past(groupCount)) << 2)));

endmodule

// File: tb/fetch_redirect_sel_test.sv
module fetch_redirect_sel_test;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] RVEC       = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rstN;
  logic        excValid, bruValid, decFixValid, btacHit, bufFull;
  logic [31:0] excAddr, bruAddr, decFixAddr, btacTarget;
  logic [31:0] fetchAddr;
  logic [2:0]  groupCount;
  logic        flush;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_redirect_sel #(.RESET_VEC(RVEC)) uut (
    .clk(clk), .rstN(rstN),
    .excValid(excValid), .excAddr(excAddr),
    .bruValid(bruValid), .bruAddr(bruAddr),
    .decFixValid(decFixValid), .decFixAddr(decFixAddr),
    .btacHit(btacHit), .btacTarget(btacTarget),
    .bufFull(bufFull),
    .fetchAddr(fetchAddr), .groupCount(groupCount), .flush(flush)
  );

  // Reference: group size from word index inside a 32-byte block
  function automatic int expCount(logic [31:0] a);
    int left = 8 - int'(a[4:2]);
    return (left < 4) ? left : 4;
  endfunction

  function automatic logic [31:0] expSeq(logic [31:0] a);
    return a + 32'(4 * expCount(a));
  endfunction

  task automatic check(string req, logic [31:0] expAddr, int expCnt, logic expFlush);
    nChecks++;
    if (fetchAddr !== expAddr || int'(groupCount) != expCnt || flush !== expFlush) begin
      nFails++;
      $display("FAIL %s: got addr=%h cnt=%0d flush=%b, expected addr=%h cnt=%0d flush=%b",
               req, fetchAddr, groupCount, flush, expAddr, expCnt, expFlush);
    end
  endtask

  task automatic idleInputs();
    excValid = 0; bruValid = 0; decFixValid = 0; btacHit = 0; bufFull = 0;
    excAddr = 32'h0; bruAddr = 32'h0; decFixAddr = 32'h0; btacTarget = 32'h0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic testReset();
    rstN = 0;
    idleInputs();
    tick(); tick();
    check("R1 in reset", RVEC, 4, 1'b0);
    rstN = 1;
    tick();
    check("R6 first step after reset", expSeq(RVEC), 4, 1'b0);
  endtask

  task automatic testSequential();
    logic [31:0] a = fetchAddr;
    for (int i = 0; i < 3; i++) begin
      a = expSeq(a);
      tick();
      check("R6 sequential", a, expCount(a), 1'b0);
    end
  endtask

  task automatic testBranchTrim();
    bruValid = 1; bruAddr = 32'h0000_0218;
    btacHit = 1; btacTarget = 32'h0000_0700;
    tick();
    idleInputs();
    check("R3/R7 branch redirect into block tail", 32'h0000_0218, 2, 1'b1);
    tick();
    check("R9/R10 next block full group", 32'h0000_0220, 4, 1'b0);
  endtask

  task automatic testExceptionWins();
    excValid = 1; excAddr = 32'h0000_0400;
    bruValid = 1; bruAddr = 32'h0000_0800;
    decFixValid = 1; decFixAddr = 32'h0000_0C00;
    btacHit = 1; btacTarget = 32'h0000_1000;
    tick();
    idleInputs();
    check("R2 exception over all", 32'h0000_0400, 4, 1'b1);
    tick();
    check("R10 flush lasts one cycle", 32'h0000_0410, 4, 1'b0);
  endtask

  task automatic testBranchOverLower();
    bruValid = 1; bruAddr = 32'h0000_0A08;
    decFixValid = 1; decFixAddr = 32'h0000_0C00;
    btacHit = 1; btacTarget = 32'h0000_1000;
    tick();
    idleInputs();
    check("R3 branch over decode and target cache", 32'h0000_0A08, 4, 1'b1);
  endtask

  task automatic testDecodeFix();
    decFixValid = 1; decFixAddr = 32'h0000_0310;
    btacHit = 1; btacTarget = 32'h0000_1000;
    tick();
    idleInputs();
    check("R4 decode fix over target cache", 32'h0000_0310, 4, 1'b1);
  endtask

  task automatic testBtacMisaligned();
    btacHit = 1; btacTarget = 32'h0000_050C;
    tick();
    idleInputs();
    check("R5/R8 target cache aligned, no flush", 32'h0000_0508, 4, 1'b0);
    tick();
    check("R7 tail of block after aligned target", 32'h0000_0518, 2, 1'b0);
    tick();
    check("R9 next block after trim", 32'h0000_0520, 4, 1'b0);
  endtask

  task automatic testBufFull();
    logic [31:0] a = fetchAddr;
    bufFull = 1;
    for (int i = 0; i < 3; i++) begin
      a = expSeq(a);
      tick();
      check("R11 full buffer ignored", a, expCount(a), 1'b0);
    end
    bufFull = 0;
  endtask

  task automatic testMidReset();
    rstN = 0;
    tick();
    check("R1 reset mid-run", RVEC, 4, 1'b0);
    rstN = 1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout, expected completion");
    finishRun();
  end

  initial begin
    rstN = 0;
    idleInputs();
    tick();
    testReset();
    testSequential();
    testBranchTrim();
    testExceptionWins();
    testBranchOverLower();
    testDecodeFix();
    testBtacMisaligned();
    testBufFull();
    testMidReset();
    tick();
    finishRun();
  end

endmodule